// File: doc/BRIEF.md
# High-Speed Packet Transmit Framer

This block turns a packet, offered one byte at a time, into the serial line-state stream for a 480 Mb/s differential link. It emits one symbol per clock: K or J, plus a drive-enable. The first byte of a packet is the packet identifier. The payload and CRC bytes follow from upstream. The framer adds the synchronisation field in front of the packet. It inserts a zero after every run of six ones and NRZI-codes every bit. It closes the packet with a deliberate bit-stuffing violation. The line has no single-ended-zero marker at this speed, which is why the violation is used.

A frame-start (SOF) packet is closed with a longer violation of 40 bits. That longer tail lets a far-end unplug be noticed from the higher differential amplitude. The source presents bytes on a valid/ready port with three flags: start of packet, last byte and is-SOF. The framer pulls the next byte only while it sends the final bit of the current one. It holds off for a cycle whenever a stuffed zero goes out.

The controlling state machine has five states:
- `ST_IDLE`: the line is undriven and a start byte is awaited.
- `ST_SYNC`: the 32 synchronisation symbols go out.
- `ST_DATA`: packet bits go out, least significant bit first.
- `ST_STUFF`: one inserted zero goes out.
- `ST_EOP`: the unstuffed violation tail goes out.

Its transitions are:
- start-accepted: `ST_IDLE` to `ST_SYNC`.
- sync-done: `ST_SYNC` to `ST_DATA`.
- run-full: `ST_DATA` to `ST_STUFF`.
- stuff-resume: `ST_STUFF` to `ST_DATA`.
- stuff-close: `ST_STUFF` to `ST_EOP`.
- data-close: `ST_DATA` to `ST_EOP`, on the last byte or on an underrun.
- tail-done: `ST_EOP` to `ST_IDLE`.

Top module: `hs_tx_framer`

## Requirements
- R1: Out of reset and in `ST_IDLE`, `line_oe` is 0, `line_k` is 0 and `in_ready` is 1. A byte offered without `in_sop` while idle is consumed and discarded, and no packet starts.
- R2: A byte accepted with `in_sop` starts the sync field. Its first symbol appears on the line two clock edges later. The field is 32 symbols that alternate K, J starting with K, and its last two symbols are both K. `line_k`=1 means K and 0 means J.
- R3: NRZI coding applies: a one bit repeats the previous line symbol and a zero bit toggles it. The level before the first sync symbol is taken as J.
- R4: Each byte is sent least significant bit first, bytes in the order accepted, the packet identifier first.
- R5: After six consecutive one bits a zero is inserted. The run count spans byte boundaries, includes the final one bit of the sync field, and restarts after any real or inserted zero.
- R6: `in_ready` is 1 during packet transmission only in the cycle that sends bit 7 of a byte not flagged `in_eop`. It is 0 while an inserted zero is sent. Exactly one byte is accepted per such cycle.
- R7: A packet whose start byte had `in_sof`=0 ends with one zero bit followed by seven one bits, all unstuffed.
- R8: A packet whose start byte had `in_sof`=1 ends with one zero bit followed by 39 one bits, all unstuffed.
- R9: After the last tail symbol `line_oe` falls on the next edge, `line_k` returns to 0 and `in_ready` is 1 again.
- R10: If `in_valid` is 0 when the next byte is requested, the packet ends there, with the normal tail, as if the previous byte had been flagged last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one symbol per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Framer takes the offered byte this cycle |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_sof | input | 1 | Packet is a frame-start packet; sampled with the first byte |
| line_k | output | 1 | Line symbol: 1 = K, 0 = J (0 when not driving) |
| line_oe | output | 1 | Driver enable |

## Verification
The bench sweeps every single-byte value and a family of two-byte packets. It predicts each symbol, its length and the per-symbol ready pattern arithmetically. This catches a stuffer that forgets the sync's trailing one or resets its run at a byte boundary; either would shift or drop an inserted zero and misalign the rest of the packet. Directed packets cover several cases:
- Six ones that end exactly on the last data bit. A design that skipped stuffing before the tail would merge them into the violation.
- A frame-start packet. A design that used the short tail there would end 32 symbols early.
- An underrun. A design that waited instead of closing would hang with the line driven.
- Non-start bytes while idle. A design that accepted them would start a spurious sync field.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_STUFF,
        ST_EOP
    } tx_state_e;

endpackage

// File: rtl/hs_tx_shifter.sv
module hs_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              shift,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            shreg_q <= load_data;
            idx_q   <= '0;
        end else if (shift) begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    assign cur_bit  = shreg_q[0];
    assign last_bit = (idx_q == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/hs_tx_stuff_ctr.sv
module hs_tx_stuff_ctr #(
    parameter int RUN_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic count_en,
    input  logic bit_in,
    output logic run_full
);
    localparam int RUN_W = $clog2(RUN_MAX + 1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (count_en) begin
            run_q <= bit_in ? run_q + RUN_W'(1) : '0;
        end
    end

    assign run_full = count_en && bit_in && (run_q == RUN_W'(RUN_MAX - 1));

    // after a full run the framer must feed a zero (or leave the packet)
    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_W'(RUN_MAX)) |=> (run_q == '0)); // R5

endmodule

// File: rtl/hs_tx_nrzi.sv
module hs_tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_idle,
    input  logic bit_in,
    output logic line_k,
    output logic line_oe
);
    always_ff @(posedge clk) begin
        if (!rst_n || hold_idle) begin
            line_k  <= 1'b0;
            line_oe <= 1'b0;
        end else begin
            line_k  <= bit_in ? line_k : ~line_k;
            line_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/hs_tx_framer.sv
module hs_tx_framer
    import hs_tx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_LEN    = 32,
    parameter int EOP_LEN     = 8,
    parameter int SOF_EOP_LEN = 40,
    parameter int RUN_MAX     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sof,
    output logic              line_k,
    output logic              line_oe
);
    localparam int CNT_TOP = (SYNC_LEN > SOF_EOP_LEN) ? SYNC_LEN : SOF_EOP_LEN;
    localparam int CNT_W   = $clog2(CNT_TOP);
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN - 1);
    localparam logic [CNT_W-1:0] EOP_END  = CNT_W'(EOP_LEN - 1);
    localparam logic [CNT_W-1:0] SOF_END  = CNT_W'(SOF_EOP_LEN - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_q, sof_q, end_q;
    logic [CNT_W-1:0] eop_end;

    logic cur_bit, load, shift, cnt_en, closing;
    logic sh_bit, sh_last, run_full;

    assign eop_end = sof_q ? SOF_END : EOP_END;
    assign closing = sh_last && (last_q || !in_valid);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= 1'b0;
            sof_q   <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
            if (load) begin
                last_q <= in_eop;
            end
            if (state_q == ST_IDLE) begin
                sof_q <= in_sof;
                end_q <= 1'b0;
            end else if (state_q == ST_DATA && closing) begin
                end_q <= 1'b1;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid && in_sop) state_d = ST_SYNC;
            ST_SYNC:  if (cnt_q == SYNC_END) state_d = ST_DATA;
            ST_DATA: begin
                if (run_full)     state_d = ST_STUFF;
                else if (closing) state_d = ST_EOP;
            end
            ST_STUFF: state_d = end_q ? ST_EOP : ST_DATA;
            ST_EOP:   if (cnt_q == eop_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and datapath control ----------------
    always_comb begin
        in_ready = 1'b0;
        cur_bit  = 1'b0;
        load     = 1'b0;
        shift    = 1'b0;
        cnt_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid && in_sop;
            end
            ST_SYNC: begin
                cur_bit = (cnt_q == SYNC_END);
                cnt_en  = 1'b1;
            end
            ST_DATA: begin
                cur_bit = sh_bit;
                cnt_en  = 1'b1;
                if (sh_last) begin
                    in_ready = !last_q;
                    load     = !last_q && in_valid;
                end else begin
                    shift = 1'b1;
                end
            end
            ST_STUFF: begin
                cur_bit = 1'b0;
                cnt_en  = 1'b1;
            end
            ST_EOP: begin
                cur_bit = (cnt_q != '0);
            end
            default: ;
        endcase
    end

    hs_tx_shifter #(.BYTE_W(BYTE_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (in_data),
        .shift     (shift),
        .cur_bit   (sh_bit),
        .last_bit  (sh_last)
    );

    hs_tx_stuff_ctr #(.RUN_MAX(RUN_MAX)) stuff_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_IDLE || state_q == ST_EOP),
        .count_en (cnt_en),
        .bit_in   (cur_bit),
        .run_full (run_full)
    );

    hs_tx_nrzi nrzi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_idle (state_q == ST_IDLE),
        .bit_in    (cur_bit),
        .line_k    (line_k),
        .line_oe   (line_oe)
    );

    // ---------------- assertions ----------------
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_k); // R1

    AST_SYNC_STARTS_K: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> line_k); // R2

    AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STUFF) |=> (line_k != $past(line_k))); // R5

    AST_STUFF_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STUFF) |-> ($past(state_q) == ST_DATA)); // R5

    AST_TAIL_ONES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOP && cnt_q != '0) |=> (line_k == $past(line_k))); // R7

    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOP && cnt_q == eop_end) |-> ##2 !line_oe); // R9

endmodule

// File: tb/hs_tx_framer_tb_top.sv
`timescale 1ns/1ps
module hs_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_sop, in_eop, in_sof;
    logic [7:0] in_data;
    logic       line_k, line_oe;

    always #2.5 clk = ~clk;

    hs_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_sof(in_sof),
        .line_k(line_k), .line_oe(line_oe)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] pkt [0:15];
    logic exp_bit [0:1023];
    logic exp_sym [0:1023];
    logic exp_rdy [0:1023];
    logic got_sym [0:1023];
    logic got_rdy [0:1023];
    int   exp_n, got_n, hs_count;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic r);
        exp_bit[exp_n] = b;
        exp_rdy[exp_n] = r;
        exp_n++;
    endtask

    task automatic build_expected(input int nb, input bit sof, input bit flag_last);
        int   run;
        logic lvl;
        exp_n = 0;
        for (int i = 0; i < 31; i++) push(1'b0, 1'b0);
        push(1'b1, 1'b0);
        run = 1;
        for (int k = 0; k < nb; k++) begin
            for (int b = 0; b < 8; b++) begin
                push(pkt[k][b], (b == 7) && !(flag_last && k == nb - 1));
                run = pkt[k][b] ? run + 1 : 0;
                if (run == 6) begin
                    push(1'b0, 1'b0);
                    run = 0;
                end
            end
        end
        push(1'b0, 1'b0);
        for (int i = 0; i < (sof ? 39 : 7); i++) push(1'b1, 1'b0);
        lvl = 1'b0;
        for (int i = 0; i < exp_n; i++) begin
            lvl = exp_bit[i] ? lvl : ~lvl;
            exp_sym[i] = lvl;
        end
    endtask

    task automatic run_packet(input int n_offer, input bit sof, input bit flag_last);
        int   bad_sym, bad_rdy, bad_sync, first_bad, tail_len;
        string tail_tag;
        build_expected(n_offer, sof, flag_last);
        hs_count = 0;
        fork
            begin : drive
                int  idx;
                logic hs;
                idx = 0;
                while (idx < n_offer) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_data  = pkt[idx];
                    in_sop   = (idx == 0);
                    in_eop   = flag_last && (idx == n_offer - 1);
                    in_sof   = sof;
                    #1;
                    hs = in_ready;
                    @(posedge clk);
                    if (hs) begin
                        idx++;
                        hs_count++;
                    end
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b0;
                in_eop   = 1'b0;
            end
            begin : capture
                logic prev_rdy;
                bit   started;
                prev_rdy = 1'b0;
                started  = 1'b0;
                got_n    = 0;
                while (1) begin
                    @(negedge clk);
                    if (line_oe) begin
                        if (got_n < 1024) begin
                            got_sym[got_n] = line_k;
                            got_rdy[got_n] = prev_rdy;
                            got_n++;
                        end
                        started = 1'b1;
                    end else if (started) begin
                        break;
                    end
                    prev_rdy = in_ready;
                end
            end
        join
        // back in idle: one negedge after the drive enable dropped
        check(in_ready === 1'b1 && line_k === 1'b0, "R9", "idle after tail (ready,k)",
              {30'd0, in_ready, line_k}, 2);
        tail_tag = sof ? "R8" : "R7";
        tail_len = sof ? 40 : 8;
        check(got_n == exp_n, tail_tag, "packet length in symbols", got_n, exp_n);
        bad_sync = 0;
        for (int i = 0; i < 32; i++)
            if (got_sym[i] !== ((i < 31) ? logic'(i % 2 == 0) : 1'b1)) bad_sync++;
        check(bad_sync == 0, "R2", "sync symbols wrong", bad_sync, 0);
        bad_sym = 0;
        first_bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_sym[i] !== exp_sym[i]) begin
                bad_sym++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad_sym == 0, "R3,R4,R5", "symbol mismatches (first index in next line)",
              bad_sym, 0);
        if (bad_sym != 0) $display("  first mismatching symbol index %0d", first_bad);
        bad_rdy = 0;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_rdy[i] !== exp_rdy[i]) bad_rdy++;
        check(bad_rdy == 0, "R6", "ready trace mismatches", bad_rdy, 0);
        bad_sym = 0;
        if (got_n >= tail_len)
            for (int i = got_n - tail_len + 1; i < got_n; i++)
                if (got_sym[i] !== got_sym[got_n - tail_len + 1]) bad_sym++;
        check(bad_sym == 0, tail_tag, "tail ones not holding level", bad_sym, 0);
        check(hs_count == n_offer, flag_last ? "R6" : "R10", "bytes accepted",
              hs_count, n_offer);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_sof = 1'b0; in_data = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(line_oe === 1'b0, "R1", "oe after reset", line_oe, 0);
        check(line_k === 1'b0, "R1", "k after reset", line_k, 0);
        check(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);

        // R1: non-start bytes while idle are dropped
        in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hFF;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(line_oe === 1'b0 && in_ready === 1'b1, "R1",
                  "idle with non-start byte (oe,ready)", {30'd0, line_oe, in_ready}, 1);
        end
        in_valid = 1'b0;
        @(negedge clk);

        // directed packets
        pkt[0] = 8'hA5;
        run_packet(1, 1'b0, 1'b1);
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
        run_packet(3, 1'b0, 1'b1);                      // R5 across bytes
        pkt[0] = 8'h1F;
        run_packet(1, 1'b0, 1'b1);                      // R5 sync one counts
        pkt[0] = 8'hFC;
        run_packet(1, 1'b0, 1'b1);                      // R5 stuff before tail
        pkt[0] = 8'hA5; pkt[1] = 8'h3F; pkt[2] = 8'hFC;
        run_packet(3, 1'b1, 1'b1);                      // R8 long tail
        pkt[0] = 8'h7F; pkt[1] = 8'hFE;
        run_packet(2, 1'b1, 1'b1);                      // R8
        pkt[0] = 8'hC3; pkt[1] = 8'h0F;
        run_packet(2, 1'b0, 1'b0);                      // R10 underrun

        // sweep: every single-byte packet, some as frame-start
        for (int v = 0; v < 256; v++) begin
            pkt[0] = 8'(v);
            run_packet(1, (v % 5) == 0, 1'b1);
        end
        // sweep: two-byte packets with runs across the byte boundary
        for (int v = 0; v < 64; v++) begin
            pkt[0] = 8'(v * 4 + 3);
            pkt[1] = ~8'(v);
            run_packet(2, 1'b0, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule